// File: doc/BRIEF.md
# In-System Programming Target Port

This block is the target side of a four-wire in-system programming link. While the active-low `prog_n` pin is held low, an external programmer clocks four-byte instructions in on `mosi` with `sck`, and the block answers on `miso`. Incoming bits are taken on rising `sck` edges and outgoing bits change on falling edges. `sck`, `mosi` and `prog_n` are brought into the `clk` domain through synchronizer stages, so `sck` must run well below `clk`. The answer during each byte is the byte that arrived just before it, which lets the programmer confirm that it is in step with the target. The one exception is the last byte of a read or status-poll instruction, which carries the requested data.

Flash words are staged in a sixteen-word page buffer and committed to a chosen page in one command. EEPROM bytes can be written one at a time, or staged in a four-byte page buffer that records which slots were filled, so that a page commit changes only those slots. Each commit drives a small on-chip memory model through a sequential write engine and holds `busy` high for a fixed number of clocks. While `busy` is high, every command except the status poll is dropped.

Top module: `isp_target`

## Requirements
- R1: Bits are sent most significant bit first on both lines. `mosi` is captured on rising `sck` edges and `miso` changes only after a falling `sck` edge. Nothing is captured while `prog_n` is high.
- R2: Every instruction is four bytes long. During byte k+1 of the stream, `miso` returns byte k. The enable instruction is `AC 53 xx xx`, so 0x53 comes back during its third byte.
- R3: After `prog_n` falls, every opcode except enable has no effect until an enable instruction has completed.
- R4: Opcode 0x40 loads the low byte and opcode 0x48 loads the high byte of one flash buffer word. The word slot is taken from byte 3 bits [3:0] and the data from byte 4.
- R5: Opcode 0x4C copies all sixteen buffer words into flash page P, where P = {byte 2 bits [1:0], byte 3 bits [7:4]}. After the copy, every buffer word is 0xFFFF again.
- R6: Opcode 0xC1 loads EEPROM buffer slot byte 3 bits [1:0] with byte 4. Opcode 0xC2 commits the buffer to EEPROM page byte 3 bits [6:2]. Only slots loaded since the last page commit are written. The loaded marks clear after each commit.
- R7: Opcode 0xC0 writes byte 4 to EEPROM address byte 3 bits [6:0]. The location is first erased to 0xFF, so the stored result equals the new data whatever the old contents were.
- R8: The three write opcodes raise `busy` on the clock after their fourth byte and hold it for exactly BUSY_CYCLES clocks. While `busy` is high, every command other than a poll is ignored. Poll (0xF0) returns {7'b0, busy} in its fourth byte.
- R9: Taking `prog_n` high drops any partial instruction, resets the byte position, revokes enable and holds `miso` low. Out of reset, `miso` and `busy` are low.
- R10: Opcodes 0x20 and 0x28 return the low and high byte of the flash word at address {byte 2 bits [1:0], byte 3}. Opcode 0xA0 returns the EEPROM byte at address byte 3 bits [6:0]. The data is returned during byte 4.
- R11: An unknown opcode still takes four bytes, changes no memory and keeps the echo behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_n | input | 1 | Programming mode select, active low |
| sck | input | 1 | Serial clock from the programmer |
| mosi | input | 1 | Serial data into the target |
| miso | output | 1 | Serial data back to the programmer |
| busy | output | 1 | High while a memory commit is in progress |

## Verification
The instruction stream is varied so that each pattern separates one pair of behaviours. Enable frames with different trailing bytes separate a true echo from a fixed reply. An EEPROM single-byte write of 0xF0 over 0x0F tells an erase-then-write from a plain AND into the cell. An EEPROM page commit over a page that was pre-filled through single-byte writes shows whether the slot mask is honoured, and a second commit shows whether stale marks were cleared. A flash page commit after only one word load tells a refilled buffer from leftover data, and a flash page number that needs byte 2 checks the address split. Back-to-back writes and a poll issued inside the busy window show that commands are dropped until the window closes. Frames cut short by `prog_n`, and frames sent before enable, show that an abort really resynchronises the link and revokes enable.

// File: rtl/isp_pkg.sv
package isp_pkg;

    // command byte values (first byte of each four-byte frame)
    localparam logic [7:0] OP_ENABLE    = 8'hAC;
    localparam logic [7:0] OP_LD_FL_LO  = 8'h40;
    localparam logic [7:0] OP_LD_FL_HI  = 8'h48;
    localparam logic [7:0] OP_WR_FL_PG  = 8'h4C;
    localparam logic [7:0] OP_RD_FL_LO  = 8'h20;
    localparam logic [7:0] OP_RD_FL_HI  = 8'h28;
    localparam logic [7:0] OP_WR_EE_BY  = 8'hC0;
    localparam logic [7:0] OP_LD_EE     = 8'hC1;
    localparam logic [7:0] OP_WR_EE_PG  = 8'hC2;
    localparam logic [7:0] OP_RD_EE     = 8'hA0;
    localparam logic [7:0] OP_POLL      = 8'hF0;

    localparam logic [7:0] ERASED_BYTE  = 8'hFF;

    typedef enum logic [1:0] {
        WK_NONE,
        WK_FLASH,
        WK_EEPAGE,
        WK_EEBYTE
    } wkind_t;

    typedef enum logic [2:0] {
        RS_ECHO,
        RS_FL_LO,
        RS_FL_HI,
        RS_EE,
        RS_POLL
    } rsel_t;

    typedef struct packed {
        logic [7:0] op;
        logic [7:0] b1;
        logic [7:0] b2;
    } frame_t;

    function automatic rsel_t pick_reply(input logic [7:0] op, input logic may_run);
        rsel_t r;
        r = RS_ECHO;
        if (op == OP_POLL)
            r = RS_POLL;
        else if (may_run) begin
            case (op)
                OP_RD_FL_LO: r = RS_FL_LO;
                OP_RD_FL_HI: r = RS_FL_HI;
                OP_RD_EE:    r = RS_EE;
                default:     r = RS_ECHO;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/isp_shifter.sv
module isp_shifter #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sck,
    input  logic       mosi,
    input  logic       prog_n,
    input  logic [7:0] reply,
    output logic       active,
    output logic       byte_valid,
    output logic [1:0] byte_idx,
    output logic [7:0] byte_data,
    output logic       miso
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sck_s, mosi_s, progn_s;
    logic       sck_q;
    logic       rise, fall;
    logic [2:0] bitcnt;
    logic [1:0] fcnt;
    logic       pend;
    logic [7:0] shreg;
    logic [7:0] tx;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_s   <= '0;
            mosi_s  <= '0;
            progn_s <= '1;
        end else begin
            sck_s   <= {sck_s[SYNC_STAGES-2:0], sck};
            mosi_s  <= {mosi_s[SYNC_STAGES-2:0], mosi};
            progn_s <= {progn_s[SYNC_STAGES-2:0], prog_n};
        end
    end

    assign active = ~progn_s[TOP];
    assign rise   = sck_s[TOP] & ~sck_q;
    assign fall   = ~sck_s[TOP] & sck_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q      <= 1'b0;
            bitcnt     <= '0;
            fcnt       <= '0;
            pend       <= 1'b0;
            shreg      <= '0;
            tx         <= '0;
            miso       <= 1'b0;
            byte_valid <= 1'b0;
            byte_idx   <= '0;
            byte_data  <= '0;
        end else begin
            sck_q      <= sck_s[TOP];
            byte_valid <= 1'b0;
            if (!active) begin
                bitcnt <= '0;
                fcnt   <= '0;
                pend   <= 1'b0;
                shreg  <= '0;
                tx     <= '0;
                miso   <= 1'b0;
            end else begin
                if (rise) begin
                    shreg  <= {shreg[6:0], mosi_s[TOP]};
                    bitcnt <= bitcnt + 3'd1;
                    if (bitcnt == 3'd7) begin
                        byte_valid <= 1'b1;
                        byte_data  <= {shreg[6:0], mosi_s[TOP]};
                        byte_idx   <= fcnt;
                        fcnt       <= fcnt + 2'd1;
                        pend       <= 1'b1;
                    end
                end
                if (fall) begin
                    if (pend) begin
                        miso <= reply[7];
                        tx   <= {reply[6:0], 1'b0};
                        pend <= 1'b0;
                    end else begin
                        miso <= tx[7];
                        tx   <= {tx[6:0], 1'b0};
                    end
                end
            end
        end
    end

endmodule

// File: rtl/isp_memory.sv
module isp_memory #(
    parameter int FL_AW = 10,
    parameter int EE_AW = 7
) (
    input  logic             clk,
    input  logic             fl_we,
    input  logic [FL_AW-1:0] fl_waddr,
    input  logic [15:0]      fl_wdata,
    input  logic             fl_re,
    input  logic [FL_AW-1:0] fl_raddr,
    output logic [15:0]      fl_rdata,
    input  logic             ee_we,
    input  logic [EE_AW-1:0] ee_waddr,
    input  logic [7:0]       ee_wdata,
    input  logic             ee_re,
    input  logic [EE_AW-1:0] ee_raddr,
    output logic [7:0]       ee_rdata
);
    localparam int FL_DEPTH = 1 << FL_AW;
    localparam int EE_DEPTH = 1 << EE_AW;

    logic [15:0] fl_mem [FL_DEPTH];
    logic [7:0]  ee_mem [EE_DEPTH];

    always_ff @(posedge clk) begin
        if (fl_we) fl_mem[fl_waddr] <= fl_wdata;
        if (fl_re) fl_rdata <= fl_mem[fl_raddr];
    end

    always_ff @(posedge clk) begin
        if (ee_we) ee_mem[ee_waddr] <= ee_wdata;
        if (ee_re) ee_rdata <= ee_mem[ee_raddr];
    end

endmodule

// File: rtl/isp_decoder.sv
module isp_decoder
    import isp_pkg::*;
#(
    parameter int FL_PAGE_WORDS = 16,
    parameter int FL_AW         = 10,
    parameter int EE_PAGE_BYTES = 4,
    parameter int EE_AW         = 7,
    parameter int BUSY_CYCLES   = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             byte_valid,
    input  logic [1:0]       byte_idx,
    input  logic [7:0]       byte_data,
    output logic             busy,
    output logic [7:0]       reply,
    output logic             fl_we,
    output logic [FL_AW-1:0] fl_waddr,
    output logic [15:0]      fl_wdata,
    output logic             fl_re,
    output logic [FL_AW-1:0] fl_raddr,
    input  logic [15:0]      fl_rdata,
    output logic             ee_we,
    output logic [EE_AW-1:0] ee_waddr,
    output logic [7:0]       ee_wdata,
    output logic             ee_re,
    output logic [EE_AW-1:0] ee_raddr,
    input  logic [7:0]       ee_rdata
);
    localparam int FL_WI  = $clog2(FL_PAGE_WORDS);
    localparam int FL_PW  = FL_AW - FL_WI;
    localparam int EE_BI  = $clog2(EE_PAGE_BYTES);
    localparam int EE_PW  = EE_AW - EE_BI;
    localparam int STEP_W = (FL_WI > EE_BI) ? FL_WI : EE_BI;
    localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);

    frame_t                   frm;
    logic [7:0]               last_byte;
    logic                     enabled;
    rsel_t                    rsel;
    wkind_t                   wkind;
    logic [STEP_W-1:0]        step;
    logic [BUSY_W-1:0]        busy_cnt;
    logic [15:0]              fbuf [FL_PAGE_WORDS];
    logic [7:0]               ebuf [EE_PAGE_BYTES];
    logic [EE_PAGE_BYTES-1:0] eload;
    logic [FL_PW-1:0]         w_fl_page;
    logic [EE_PW-1:0]         w_ee_page;
    logic [EE_AW-1:0]         w_ee_addr;
    logic [7:0]               w_ee_data;

    logic             exec, may_run, addr_phase, last_step;
    logic [15:0]      fl_cat;
    logic [FL_AW-1:0] fl_cmd_addr;
    logic [FL_WI-1:0] fl_slot;
    logic [EE_BI-1:0] ee_slot;
    logic [EE_BI-1:0] step_ee;

    assign busy        = (busy_cnt != '0);
    assign may_run     = enabled && !busy;
    assign exec        = byte_valid && (byte_idx == 2'd3);
    assign addr_phase  = byte_valid && (byte_idx == 2'd2);
    assign fl_cat      = {frm.b1, frm.b2};
    assign fl_cmd_addr = fl_cat[FL_AW-1:0];
    assign fl_slot     = frm.b2[FL_WI-1:0];
    assign ee_slot     = frm.b2[EE_BI-1:0];
    assign step_ee     = step[EE_BI-1:0];

    // read port: address is complete once the third byte has arrived
    always_comb begin
        logic [15:0] rd_cat;
        rd_cat   = {frm.b1, byte_data};
        fl_raddr = rd_cat[FL_AW-1:0];
        ee_raddr = byte_data[EE_AW-1:0];
        fl_re    = addr_phase && may_run &&
                   (frm.op == OP_RD_FL_LO || frm.op == OP_RD_FL_HI);
        ee_re    = addr_phase && may_run && (frm.op == OP_RD_EE);
    end

    always_comb begin
        case (rsel)
            RS_FL_LO: reply = fl_rdata[7:0];
            RS_FL_HI: reply = fl_rdata[15:8];
            RS_EE:    reply = ee_rdata;
            RS_POLL:  reply = {7'b0, busy};
            default:  reply = last_byte;
        endcase
    end

    // sequential write engine, one memory write per clock
    always_comb begin
        fl_we    = (wkind == WK_FLASH);
        fl_waddr = {w_fl_page, step[FL_WI-1:0]};
        fl_wdata = fbuf[step[FL_WI-1:0]];
        ee_we    = 1'b0;
        ee_waddr = w_ee_addr;
        ee_wdata = w_ee_data;
        case (wkind)
            WK_EEPAGE: begin
                ee_we    = eload[step_ee];
                ee_waddr = {w_ee_page, step_ee};
                ee_wdata = ebuf[step_ee];
            end
            WK_EEBYTE: begin
                ee_we    = 1'b1;
                ee_wdata = (step == '0) ? ERASED_BYTE : w_ee_data;
            end
            default: ;
        endcase
        case (wkind)
            WK_FLASH:  last_step = (step == STEP_W'(FL_PAGE_WORDS - 1));
            WK_EEPAGE: last_step = (step == STEP_W'(EE_PAGE_BYTES - 1));
            WK_EEBYTE: last_step = (step == STEP_W'(1));
            default:   last_step = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frm       <= '0;
            last_byte <= '0;
            enabled   <= 1'b0;
            rsel      <= RS_ECHO;
            wkind     <= WK_NONE;
            step      <= '0;
            busy_cnt  <= '0;
            eload     <= '0;
            w_fl_page <= '0;
            w_ee_page <= '0;
            w_ee_addr <= '0;
            w_ee_data <= '0;
            for (int i = 0; i < FL_PAGE_WORDS; i++) fbuf[i] <= 16'hFFFF;
            for (int i = 0; i < EE_PAGE_BYTES; i++) ebuf[i] <= '0;
        end else begin
            if (!active) begin
                enabled <= 1'b0;
                rsel    <= RS_ECHO;
            end

            if (busy) busy_cnt <= busy_cnt - BUSY_W'(1);

            if (wkind != WK_NONE) begin
                step <= step + STEP_W'(1);
                if (last_step) begin
                    if (wkind == WK_FLASH)
                        for (int i = 0; i < FL_PAGE_WORDS; i++) fbuf[i] <= 16'hFFFF;
                    if (wkind == WK_EEPAGE)
                        eload <= '0;
                    wkind <= WK_NONE;
                end
            end

            if (byte_valid) begin
                last_byte <= byte_data;
                case (byte_idx)
                    2'd0: frm.op <= byte_data;
                    2'd1: frm.b1 <= byte_data;
                    2'd2: begin
                        frm.b2 <= byte_data;
                        rsel   <= enabled ? pick_reply(frm.op, may_run) : RS_ECHO;
                    end
                    default: rsel <= RS_ECHO;
                endcase
            end

            if (exec) begin
                if (frm.op == OP_ENABLE) begin
                    enabled <= 1'b1;
                end else if (may_run) begin
                    case (frm.op)
                        OP_LD_FL_LO: fbuf[fl_slot][7:0]  <= byte_data;
                        OP_LD_FL_HI: fbuf[fl_slot][15:8] <= byte_data;
                        OP_LD_EE: begin
                            ebuf[ee_slot]  <= byte_data;
                            eload[ee_slot] <= 1'b1;
                        end
                        OP_WR_FL_PG: begin
                            w_fl_page <= fl_cmd_addr[FL_AW-1:FL_WI];
                            wkind     <= WK_FLASH;
                            step      <= '0;
                            busy_cnt  <= BUSY_W'(BUSY_CYCLES);
                        end
                        OP_WR_EE_PG: begin
                            w_ee_page <= frm.b2[EE_AW-1:EE_BI];
                            wkind     <= WK_EEPAGE;
                            step      <= '0;
                            busy_cnt  <= BUSY_W'(BUSY_CYCLES);
                        end
                        OP_WR_EE_BY: begin
                            w_ee_addr <= frm.b2[EE_AW-1:0];
                            w_ee_data <= byte_data;
                            wkind     <= WK_EEBYTE;
                            step      <= '0;
                            busy_cnt  <= BUSY_W'(BUSY_CYCLES);
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/isp_target.sv
module isp_target #(
    parameter int FL_PAGES      = 64,
    parameter int FL_PAGE_WORDS = 16,
    parameter int EE_PAGES      = 32,
    parameter int EE_PAGE_BYTES = 4,
    parameter int BUSY_CYCLES   = 64,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic prog_n,
    input  logic sck,
    input  logic mosi,
    output logic miso,
    output logic busy
);
    localparam int FL_AW = $clog2(FL_PAGES) + $clog2(FL_PAGE_WORDS);
    localparam int EE_AW = $clog2(EE_PAGES) + $clog2(EE_PAGE_BYTES);

    logic             active, byte_valid;
    logic [1:0]       byte_idx;
    logic [7:0]       byte_data, reply;
    logic             fl_we, fl_re, ee_we, ee_re;
    logic [FL_AW-1:0] fl_waddr, fl_raddr;
    logic [15:0]      fl_wdata, fl_rdata;
    logic [EE_AW-1:0] ee_waddr, ee_raddr;
    logic [7:0]       ee_wdata, ee_rdata;

    isp_shifter #(.SYNC_STAGES(SYNC_STAGES)) u_shift (
        .clk(clk), .rst(rst), .sck(sck), .mosi(mosi), .prog_n(prog_n),
        .reply(reply), .active(active), .byte_valid(byte_valid),
        .byte_idx(byte_idx), .byte_data(byte_data), .miso(miso)
    );

    isp_decoder #(
        .FL_PAGE_WORDS(FL_PAGE_WORDS), .FL_AW(FL_AW),
        .EE_PAGE_BYTES(EE_PAGE_BYTES), .EE_AW(EE_AW),
        .BUSY_CYCLES(BUSY_CYCLES)
    ) u_dec (
        .clk(clk), .rst(rst), .active(active), .byte_valid(byte_valid),
        .byte_idx(byte_idx), .byte_data(byte_data), .busy(busy), .reply(reply),
        .fl_we(fl_we), .fl_waddr(fl_waddr), .fl_wdata(fl_wdata),
        .fl_re(fl_re), .fl_raddr(fl_raddr), .fl_rdata(fl_rdata),
        .ee_we(ee_we), .ee_waddr(ee_waddr), .ee_wdata(ee_wdata),
        .ee_re(ee_re), .ee_raddr(ee_raddr), .ee_rdata(ee_rdata)
    );

    isp_memory #(.FL_AW(FL_AW), .EE_AW(EE_AW)) u_mem (
        .clk(clk),
        .fl_we(fl_we), .fl_waddr(fl_waddr), .fl_wdata(fl_wdata),
        .fl_re(fl_re), .fl_raddr(fl_raddr), .fl_rdata(fl_rdata),
        .ee_we(ee_we), .ee_waddr(ee_waddr), .ee_wdata(ee_wdata),
        .ee_re(ee_re), .ee_raddr(ee_raddr), .ee_rdata(ee_rdata)
    );

endmodule

// File: rtl/isp_target_chk.sv
module isp_target_chk #(
    parameter int BUSY_CYCLES = 64
) (
    input logic       clk,
    input logic       rst,
    input logic       prog_n,
    input logic       sck,
    input logic       miso,
    input logic       busy,
    input logic       byte_valid,
    input logic [1:0] byte_idx
);
    logic [2:0]  since_rst;
    logic [31:0] busy_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= '0;
            busy_run  <= '0;
        end else begin
            if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
            busy_run <= busy ? busy_run + 32'd1 : 32'd0;
        end
    end

    // R8: busy never lasts longer than its window
    assert_busy_len_R8: assert property (@(posedge clk) disable iff (rst)
        busy_run <= BUSY_CYCLES);

    // R8: busy only starts right after the last byte of a frame
    assert_busy_cause_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(byte_valid) && $past(byte_idx) == 2'd3));

    // R9: miso held low once prog_n high has passed the synchronizer
    assert_quiet_miso_R9: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 3'd5 && $past(prog_n, 3)) |-> !miso);

    // R1: miso only moves after sck was seen low
    assert_miso_on_fall_R1: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 3'd5 && $changed(miso) && !$past(prog_n, 3)) |-> !$past(sck, 3));

endmodule

bind isp_target isp_target_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
    .clk(clk), .rst(rst), .prog_n(prog_n), .sck(sck), .miso(miso),
    .busy(busy), .byte_valid(byte_valid), .byte_idx(byte_idx)
);

// File: tb/sim_isp_target.sv
module sim_isp_target;
    localparam int BUSY = 700;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst, prog_n, sck, mosi;
    logic miso, busy;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] obs_q[$];

    always #5 clk = ~clk;

    isp_target #(.BUSY_CYCLES(BUSY)) u0 (
        .clk(clk), .rst(rst), .prog_n(prog_n), .sck(sck),
        .mosi(mosi), .miso(miso), .busy(busy)
    );

    task automatic direct(input logic [7:0] got, input logic [7:0] exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    // monitor: compares observed bytes against the scoreboard queue
    initial begin
        forever begin
            @(negedge clk);
            while (obs_q.size() != 0 && exp_q.size() != 0) begin
                logic [7:0] g, e;
                string t;
                g = obs_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                direct(g, e, t);
            end
        end
    end

    task automatic xbyte(input logic [7:0] d, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) begin
            mosi = d[i];
            repeat (HALF) @(negedge clk);
            r[i] = miso;
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic frame(input logic [7:0] a, b, c, d, output logic [7:0] r3, r4);
        logic [7:0] r1, r2;
        xbyte(a, r1);
        xbyte(b, r2);
        xbyte(c, r3);
        xbyte(d, r4);
        repeat (2 * HALF) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] a, b, c, d);
        logic [7:0] r3, r4;
        frame(a, b, c, d, r3, r4);
    endtask

    // driver: push the expectation, run the frame, hand the observed byte over
    task automatic cmd(input logic [7:0] a, b, c, d, input int at,
                       input logic [7:0] exp, input string tag);
        logic [7:0] r3, r4;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        frame(a, b, c, d, r3, r4);
        obs_q.push_back(at == 3 ? r3 : r4);
    endtask

    task automatic idle();
        repeat (BUSY + 20) @(negedge clk);
    endtask

    task automatic enable();
        send(8'hAC, 8'h53, 8'h00, 8'h00);
    endtask

    task automatic ee_write(input logic [7:0] addr, input logic [7:0] data);
        send(8'hC0, 8'h00, addr, data);
        idle();
    endtask

    task automatic reopen();
        prog_n = 1'b1;
        repeat (20) @(negedge clk);
        prog_n = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] tmp;
        rst = 1'b1; prog_n = 1'b1; sck = 1'b0; mosi = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        direct({7'b0, miso}, 8'h00, "R9 reset miso");
        direct({7'b0, busy}, 8'h00, "R9 reset busy");

        prog_n = 1'b0;
        repeat (10) @(negedge clk);

        // R2 / R1: echo of 0x53 in byte three, then of byte three in byte four
        cmd(8'hAC, 8'h53, 8'h12, 8'h34, 3, 8'h53, "R2 enable echo");
        cmd(8'hAC, 8'h53, 8'h12, 8'h34, 4, 8'h12, "R1 echo of byte three");

        // R3: commands before enable do nothing
        ee_write(8'h05, 8'h3C);
        reopen();
        ee_write(8'h05, 8'h99);
        enable();
        cmd(8'hA0, 8'h00, 8'h05, 8'h00, 4, 8'h3C, "R3 write before enable");

        // R7: erase then write, not an AND into the old value
        ee_write(8'h06, 8'h0F);
        ee_write(8'h06, 8'hF0);
        cmd(8'hA0, 8'h00, 8'h06, 8'h00, 4, 8'hF0, "R7 erase before write");

        // R8: busy window, poll, and commands dropped while busy
        send(8'hC0, 8'h00, 8'h14, 8'h66);
        direct({7'b0, busy}, 8'h01, "R8 busy port after write");
        cmd(8'hF0, 8'h00, 8'h00, 8'h00, 4, 8'h01, "R8 poll while busy");
        idle();
        cmd(8'hF0, 8'h00, 8'h00, 8'h00, 4, 8'h00, "R8 poll when idle");
        send(8'hC0, 8'h00, 8'h15, 8'h66);
        send(8'hC0, 8'h00, 8'h15, 8'h77);
        idle();
        cmd(8'hA0, 8'h00, 8'h15, 8'h00, 4, 8'h66, "R8 write dropped while busy");

        // R4 / R5 / R10: flash page 3
        send(8'h40, 8'h00, 8'h00, 8'h34);
        send(8'h48, 8'h00, 8'h00, 8'h12);
        send(8'h40, 8'h00, 8'h0F, 8'hCD);
        send(8'h48, 8'h00, 8'h0F, 8'hAB);
        send(8'h4C, 8'h00, 8'h30, 8'h00);
        idle();
        cmd(8'h20, 8'h00, 8'h30, 8'h00, 4, 8'h34, "R10 flash low byte");
        cmd(8'h28, 8'h00, 8'h30, 8'h00, 4, 8'h12, "R4 flash high byte");
        cmd(8'h28, 8'h00, 8'h3F, 8'h00, 4, 8'hAB, "R4 flash word 15");
        cmd(8'h20, 8'h00, 8'h37, 8'h00, 4, 8'hFF, "R5 unloaded word");
        // R5: page 37 needs byte two; buffer must be back to all ones
        send(8'h40, 8'h00, 8'h02, 8'h5A);
        send(8'h48, 8'h00, 8'h02, 8'hA5);
        send(8'h4C, 8'h02, 8'h50, 8'h00);
        idle();
        cmd(8'h20, 8'h02, 8'h52, 8'h00, 4, 8'h5A, "R5 high page word");
        cmd(8'h28, 8'h02, 8'h52, 8'h00, 4, 8'hA5, "R5 high page high byte");
        cmd(8'h20, 8'h02, 8'h50, 8'h00, 4, 8'hFF, "R5 buffer refilled");

        // R6: masked EEPROM page commit over page 2
        ee_write(8'h08, 8'h11);
        ee_write(8'h09, 8'h22);
        ee_write(8'h0A, 8'h33);
        ee_write(8'h0B, 8'h44);
        send(8'hC1, 8'h00, 8'h09, 8'hA1);
        send(8'hC1, 8'h00, 8'h0B, 8'hA3);
        send(8'hC2, 8'h00, 8'h08, 8'h00);
        idle();
        cmd(8'hA0, 8'h00, 8'h08, 8'h00, 4, 8'h11, "R6 slot 0 kept");
        cmd(8'hA0, 8'h00, 8'h09, 8'h00, 4, 8'hA1, "R6 slot 1 written");
        cmd(8'hA0, 8'h00, 8'h0A, 8'h00, 4, 8'h33, "R6 slot 2 kept");
        cmd(8'hA0, 8'h00, 8'h0B, 8'h00, 4, 8'hA3, "R6 slot 3 written");
        // R6: marks cleared after commit
        ee_write(8'h11, 8'h55);
        send(8'hC1, 8'h00, 8'h10, 8'hB0);
        send(8'hC2, 8'h00, 8'h10, 8'h00);
        idle();
        cmd(8'hA0, 8'h00, 8'h10, 8'h00, 4, 8'hB0, "R6 new slot written");
        cmd(8'hA0, 8'h00, 8'h11, 8'h00, 4, 8'h55, "R6 stale mark cleared");

        // R11: unknown opcode
        cmd(8'h77, 8'h01, 8'h02, 8'h03, 4, 8'h02, "R11 unknown echo");
        cmd(8'hA0, 8'h00, 8'h09, 8'h00, 4, 8'hA1, "R11 no memory change");

        // R9: abort in mid frame, then resynchronise
        xbyte(8'hA0, tmp);
        xbyte(8'h00, tmp);
        prog_n = 1'b1;
        repeat (10) @(negedge clk);
        direct({7'b0, miso}, 8'h00, "R9 miso low after abort");
        prog_n = 1'b0;
        repeat (10) @(negedge clk);
        enable();
        cmd(8'hA0, 8'h00, 8'h08, 8'h00, 4, 8'h11, "R9 realigned read");

        repeat (20) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule